// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the timing for a successive-approximation converter controller. It divides the system clock into a conversion-clock enable pulse, using one of eight ratios. Each conversion is then run as a sampling window followed by a fixed resolving window. Both windows are counted in conversion-clock periods. A 2-bit mode field sets the length of the sampling window. When the block is first enabled, one start-up delay is placed ahead of the first conversion only. The comparator and the result storage sit outside this block.

The divider and mode fields are captured only while the enable bit is low, so a change made while the block runs has no effect. A start request is held until the next conversion-clock pulse, so every window is a whole number of conversion-clock periods long. Dropping the enable bit ends any activity at once.

States and transitions of the controller:

- IDLE goes to ALIGN on a start with a supported mode.
- ALIGN waits for the next conversion-clock pulse. On that pulse it goes to STARTUP if this is the first conversion since enable rose, otherwise to SAMPLE.
- STARTUP counts 4 pulses and then goes to SAMPLE.
- SAMPLE counts 7 or 5 pulses, depending on the mode, and then goes to CONVERT.
- CONVERT counts 12 pulses and then goes to DONE.
- DONE lasts one cycle and returns to IDLE.
- Any state goes to IDLE in the cycle after enable is seen low. That transition also re-arms STARTUP.

Top module: `adc_timing_seq`

## Requirements
- R1: While reset is asserted, and after it is released, all four outputs are low until the block is enabled and started.
- R2: `conv_clk_en` is a one-cycle pulse that repeats every N system clocks while enabled. N is 64, 32, 16, 8, 6, 5, 4 or 2 for `div_sel` = 0 through 7. It is low in the cycle after enable is seen low.
- R3: With `mode_sel` = 2'b10, `sample_active` is high for 7·N cycles and is followed directly by `convert_active` high for 12·N cycles, 19·N in total.
- R4: With `mode_sel` = 2'b11, `sample_active` is high for 5·N cycles and is followed directly by `convert_active` high for 12·N cycles, 17·N in total.
- R5: On the first conversion after enable rises, 5 `conv_clk_en` pulses occur after the start and before `sample_active` rises: the alignment pulse plus 4 start-up periods. On later conversions only the alignment pulse occurs.
- R6: Changes to `div_sel` or `mode_sel` while `enable` is high have no effect on timing, both during a conversion and between conversions.
- R7: With `mode_sel` = 2'b00 or 2'b01, a start is rejected: no strobe and no `done` follow.
- R8: `done` is high for exactly one cycle, in the cycle right after the last `convert_active` cycle.
- R9: Clearing `enable` during a conversion drops both strobes in the next cycle, produces no `done`, and makes the next conversion include the start-up delay again.
- R10: The sampling window begins in the cycle after a `conv_clk_en` pulse. A start that arrives while a conversion is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable. Configuration is captured while it is low |
| start | input | 1 | Conversion request, sampled on the clock edge |
| div_sel | input | 3 | Conversion-clock ratio select |
| mode_sel | input | 2 | Sampling-length mode |
| conv_clk_en | output | 1 | Conversion-clock enable pulse |
| sample_active | output | 1 | High during the sampling window |
| convert_active | output | 1 | High during the resolving window |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The hardest state to reach is an abort in the middle of a window, followed by a re-enable, because the re-armed start-up delay only shows up on the next conversion. The stimulus waits until `sample_active` is high, drops `enable`, and watches for several hundred cycles that no `done` appears. It then re-enables and counts conversion-clock pulses before sampling begins. Configuration freezing is reached in a similar way. The fields are scrambled right after a start and left scrambled across a back-to-back second conversion, and the window lengths must still match the values captured earlier.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_STARTUP,
        ST_SAMPLE,
        ST_CONVERT,
        ST_DONE
    } seq_state_t;

    localparam int MAX_RATIO = 64;
    localparam int RATIO_W   = $clog2(MAX_RATIO) + 1;

    localparam logic [1:0] MODE_LV1 = 2'b10;
    localparam logic [1:0] MODE_LV2 = 2'b11;

    function automatic logic [RATIO_W-1:0] div_ratio(input logic [2:0] sel);
        logic [RATIO_W-1:0] r;
        unique case (sel)
            3'd0: r = RATIO_W'(64);
            3'd1: r = RATIO_W'(32);
            3'd2: r = RATIO_W'(16);
            3'd3: r = RATIO_W'(8);
            3'd4: r = RATIO_W'(6);
            3'd5: r = RATIO_W'(5);
            3'd6: r = RATIO_W'(4);
            default: r = RATIO_W'(2);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/adc_cfg_hold.sv
module adc_cfg_hold #(
    parameter int DIV_W  = 3,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [MODE_W-1:0] mode_sel,
    output logic [DIV_W-1:0]  div_q,
    output logic [MODE_W-1:0] mode_q
);
    // Fields follow the inputs only while the converter is stopped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            mode_q <= '0;
        end else if (!enable) begin
            div_q  <= div_sel;
            mode_q <= mode_sel;
        end
    end
endmodule

// File: rtl/adc_clkdiv.sv
module adc_clkdiv
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_q,
    output logic             tick
);
    localparam int CNT_W = $clog2(MAX_RATIO);

    logic [CNT_W-1:0]   cnt;
    logic               run_q;
    logic [RATIO_W-1:0] ratio;

    assign ratio = div_ratio(div_q);
    assign tick  = run_q && (cnt == CNT_W'(ratio - RATIO_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= enable;
            if (!enable || tick) cnt <= '0;
            else                 cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int MODE_W        = 2,
    parameter int STARTUP_TICKS = 4,
    parameter int SAMP_LV1      = 7,
    parameter int SAMP_LV2      = 5,
    parameter int CONV_TICKS    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              tick,
    input  logic [MODE_W-1:0] mode_q,
    output logic              sample_active,
    output logic              convert_active,
    output logic              done
);
    localparam int MAX_PH = (CONV_TICKS > SAMP_LV1) ? CONV_TICKS : SAMP_LV1;
    localparam int PH_W   = $clog2(MAX_PH + 1);

    seq_state_t      st, st_n;
    logic [PH_W-1:0] ph, ph_n;
    logic            first, first_n;
    logic            mode_ok;
    logic [PH_W-1:0] samp_last;

    assign mode_ok   = (mode_q == MODE_LV1) || (mode_q == MODE_LV2);
    assign samp_last = (mode_q == MODE_LV2) ? PH_W'(SAMP_LV2 - 1) : PH_W'(SAMP_LV1 - 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            ph    <= '0;
            first <= 1'b1;
        end else begin
            st    <= st_n;
            ph    <= ph_n;
            first <= first_n;
        end
    end

    // Next-state logic
    always_comb begin
        st_n    = st;
        ph_n    = ph;
        first_n = first;
        if (!enable) begin
            st_n    = ST_IDLE;
            ph_n    = '0;
            first_n = 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start && mode_ok) st_n = ST_ALIGN;
                end
                ST_ALIGN: begin
                    if (tick) begin
                        ph_n = '0;
                        st_n = first ? ST_STARTUP : ST_SAMPLE;
                    end
                end
                ST_STARTUP: begin
                    if (tick) begin
                        if (ph == PH_W'(STARTUP_TICKS - 1)) begin
                            ph_n    = '0;
                            first_n = 1'b0;
                            st_n    = ST_SAMPLE;
                        end else begin
                            ph_n = ph + PH_W'(1);
                        end
                    end
                end
                ST_SAMPLE: begin
                    if (tick) begin
                        if (ph == samp_last) begin
                            ph_n = '0;
                            st_n = ST_CONVERT;
                        end else begin
                            ph_n = ph + PH_W'(1);
                        end
                    end
                end
                ST_CONVERT: begin
                    if (tick) begin
                        if (ph == PH_W'(CONV_TICKS - 1)) begin
                            ph_n = '0;
                            st_n = ST_DONE;
                        end else begin
                            ph_n = ph + PH_W'(1);
                        end
                    end
                end
                ST_DONE: st_n = ST_IDLE;
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sample_active  = (st == ST_SAMPLE);
        convert_active = (st == ST_CONVERT);
        done           = (st == ST_DONE);
    end
endmodule

// File: rtl/adc_timing_seq.sv
module adc_timing_seq #(
    parameter int DIV_W         = 3,
    parameter int MODE_W        = 2,
    parameter int STARTUP_TICKS = 4,
    parameter int SAMP_LV1      = 7,
    parameter int SAMP_LV2      = 5,
    parameter int CONV_TICKS    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [MODE_W-1:0] mode_sel,
    output logic              conv_clk_en,
    output logic              sample_active,
    output logic              convert_active,
    output logic              done
);
    logic [DIV_W-1:0]  div_q;
    logic [MODE_W-1:0] mode_q;

    adc_cfg_hold #(.DIV_W(DIV_W), .MODE_W(MODE_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .div_sel (div_sel),
        .mode_sel(mode_sel),
        .div_q   (div_q),
        .mode_q  (mode_q)
    );

    adc_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(enable),
        .div_q (div_q),
        .tick  (conv_clk_en)
    );

    adc_seq_fsm #(
        .MODE_W       (MODE_W),
        .STARTUP_TICKS(STARTUP_TICKS),
        .SAMP_LV1     (SAMP_LV1),
        .SAMP_LV2     (SAMP_LV2),
        .CONV_TICKS   (CONV_TICKS)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .start         (start),
        .tick          (conv_clk_en),
        .mode_q        (mode_q),
        .sample_active (sample_active),
        .convert_active(convert_active),
        .done          (done)
    );
endmodule

// File: rtl/adc_timing_seq_chk.sv
module adc_timing_seq_chk #(
    parameter int DIV_W  = 3,
    parameter int MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              start,
    input logic [DIV_W-1:0]  div_sel,
    input logic [MODE_W-1:0] mode_sel,
    input logic              conv_clk_en,
    input logic              sample_active,
    input logic              convert_active,
    input logic              done
);
    assert_tick_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !conv_clk_en);

    assert_tick_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_clk_en |=> !conv_clk_en);

    assert_sample_then_convert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sample_active) && $past(enable)) |-> convert_active);

    assert_done_after_convert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(convert_active) && $past(conv_clk_en)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sample_active && !convert_active && !done));

    assert_sample_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_active) |-> $past(conv_clk_en));
endmodule

bind adc_timing_seq adc_timing_seq_chk #(.DIV_W(DIV_W), .MODE_W(MODE_W)) u_chk (.*);

// File: tb/tb_adc_timing_seq.sv
module tb_adc_timing_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       start = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic [1:0] mode_sel = 2'b10;
    logic       conv_clk_en, sample_active, convert_active, done;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;
    int strobe_seen = 0;

    always #10 clk = ~clk;   // 50 MHz

    adc_timing_seq dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .div_sel(div_sel), .mode_sel(mode_sel),
        .conv_clk_en(conv_clk_en), .sample_active(sample_active),
        .convert_active(convert_active), .done(done)
    );

    function automatic int rat(input int d);
        int t[8] = '{64, 32, 16, 8, 6, 5, 4, 2};
        return t[d];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: phase name plus periods left in that phase.
    int m_ph = 0, m_left = 0, m_cnt = 0, m_div = 0, m_mode = 0;
    bit m_first = 1, m_run = 0, m_tk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_cnt = 0; m_div = 0; m_mode = 0; m_first = 1; m_run = 0;
        end else begin
            m_tk = m_run && (m_cnt == rat(m_div) - 1);
            if (!enable) begin
                m_ph = 0; m_first = 1;
            end else begin
                case (m_ph)
                    0: if (start && m_mode >= 2) m_ph = 1;
                    1: if (m_tk) begin
                           if (m_first) begin m_ph = 2; m_left = 4; end
                           else begin m_ph = 3; m_left = (m_mode == 3) ? 5 : 7; end
                       end
                    2: if (m_tk) begin
                           m_left--;
                           if (m_left == 0) begin m_ph = 3; m_first = 0; m_left = (m_mode == 3) ? 5 : 7; end
                       end
                    3: if (m_tk) begin
                           m_left--;
                           if (m_left == 0) begin m_ph = 4; m_left = 12; end
                       end
                    4: if (m_tk) begin
                           m_left--;
                           if (m_left == 0) m_ph = 5;
                       end
                    default: m_ph = 0;
                endcase
            end
            m_cnt = (!enable || m_tk) ? 0 : m_cnt + 1;
            m_run = enable;
            if (!enable) begin m_div = div_sel; m_mode = mode_sel; end
        end
    end

    // Every-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(conv_clk_en == (m_run && m_cnt == rat(m_div) - 1), "R2 model conv_clk_en",
                conv_clk_en, m_run && m_cnt == rat(m_div) - 1);
            chk(sample_active == (m_ph == 3), "R3 model sample_active", sample_active, m_ph == 3);
            chk(convert_active == (m_ph == 4), "R4 model convert_active", convert_active, m_ph == 4);
            chk(done == (m_ph == 5), "R8 model done", done, m_ph == 5);
            if (done) done_seen++;
            if (sample_active || convert_active) strobe_seen++;
        end
    end

    task automatic configure(input int d, input int m);
        @(negedge clk);
        enable = 1'b0; div_sel = 3'(d); mode_sel = 2'(m);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_conv(input int exp_ticks, input int exp_samp, input int exp_conv,
                            input bit scramble, input string tag);
        int tk = 0, len = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin div_sel = ~div_sel; mode_sel = ~mode_sel; end
        @(negedge clk);
        while (!sample_active) begin
            if (conv_clk_en) tk++;
            @(negedge clk);
        end
        chk(tk == exp_ticks, {tag, " R5 pulses before sampling"}, tk, exp_ticks);
        while (sample_active) begin
            if (len == 2) begin start = 1'b1; @(negedge clk); start = 1'b0; len++; continue; end // R10 busy start
            len++; @(negedge clk);
        end
        chk(len == exp_samp, {tag, " sample length"}, len, exp_samp);
        chk(convert_active == 1'b1, {tag, " R3 convert follows sample"}, convert_active, 1);
        len = 0;
        while (convert_active) begin len++; @(negedge clk); end
        chk(len == exp_conv, {tag, " convert length"}, len, exp_conv);
        chk(done == 1'b1, {tag, " R8 done right after convert"}, done, 1);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
        chk(sample_active == 1'b0, {tag, " R10 busy start ignored"}, sample_active, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, d0;
        repeat (3) @(negedge clk);
        chk({conv_clk_en, sample_active, convert_active, done} == 4'b0, "R1 outputs in reset",
            {conv_clk_en, sample_active, convert_active, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({conv_clk_en, sample_active, convert_active, done} == 4'b0, "R1 outputs after reset",
            {conv_clk_en, sample_active, convert_active, done}, 0);

        // R2: each divider encoding
        for (int d = 0; d < 8; d++) begin
            configure(d, 2);
            while (!conv_clk_en) @(negedge clk);
            n = 0;
            @(negedge clk); n++;
            while (!conv_clk_en) begin @(negedge clk); n++; end
            chk(n == rat(d), $sformatf("R2 period div_sel=%0d", d), n, rat(d));
        end
        enable = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(conv_clk_en == 1'b0, "R2 pulse stops when disabled", conv_clk_en, 0);

        // R3: mode 10 divide by 2, then back to back
        configure(7, 2);
        run_conv(5, 7 * 2, 12 * 2, 0, "R3 div2 first");
        run_conv(1, 7 * 2, 12 * 2, 0, "R3 R5 div2 second");

        // R4: mode 11 divide by 6
        configure(4, 3);
        run_conv(5, 5 * 6, 12 * 6, 0, "R4 div6 first");
        // divide by 5, mode 10
        configure(5, 2);
        run_conv(5, 7 * 5, 12 * 5, 0, "R3 div5 first");
        run_conv(1, 7 * 5, 12 * 5, 0, "R3 div5 second");

        // R6: fields scrambled while enabled
        configure(6, 3);
        run_conv(5, 5 * 4, 12 * 4, 1, "R6 during conversion");
        run_conv(1, 5 * 4, 12 * 4, 1, "R6 between conversions");

        // R7: unsupported modes rejected
        for (int m = 0; m < 2; m++) begin
            configure(7, m);
            d0 = done_seen; n = strobe_seen;
            start = 1'b1; @(negedge clk); start = 1'b0;
            repeat (200) @(negedge clk);
            chk(done_seen == d0, $sformatf("R7 no done mode=%0d", m), done_seen - d0, 0);
            chk(strobe_seen == n, $sformatf("R7 no strobe mode=%0d", m), strobe_seen - n, 0);
        end

        // R9: abort in mid sampling, then re-arm
        configure(3, 2);
        start = 1'b1; @(negedge clk); start = 1'b0;
        while (!sample_active) @(negedge clk);
        repeat (10) @(negedge clk);
        d0 = done_seen;
        enable = 1'b0;
        @(negedge clk);
        chk(!sample_active && !convert_active, "R9 strobes drop", sample_active | convert_active, 0);
        repeat (300) @(negedge clk);
        chk(done_seen == d0, "R9 no done after abort", done_seen - d0, 0);
        enable = 1'b1;
        @(negedge clk);
        run_conv(5, 7 * 8, 12 * 8, 0, "R9 re-armed start-up");

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule